// File: doc/BRIEF.md
# I2C Master SCL Phase Timer

This block paces the clock line of an I2C master. A down-counter is loaded with a reload value taken from the low bits of a configuration byte. It decrements once on every cycle in which the decrement-enable strobe is high. The system supplies that strobe twice per instruction cycle, on two evenly spaced oscillator phases, with four oscillator clocks to one instruction cycle. When the counter reaches zero it stops there. The next strobe then produces a one-cycle expiry pulse, and the timer moves on to the next phase of the clock line. Software writes no reload for each bit.

A four-state machine sequences the phases. In `PH_IDLE` the line is released and the counter is zero. A run request moves it to `PH_LOW`: the line is driven low and the counter is loaded. Expiry in `PH_LOW` moves it to `PH_WAIT`: the line is released and the counter holds at zero. `PH_WAIT` waits until a two-flop synchronised copy of the real line level reads high, and then moves to `PH_HIGH` and reloads. A slave that stretches the clock therefore lengthens the high phase by exactly the time it holds the line low. Expiry in `PH_HIGH` moves to `PH_LOW` with a fresh reload when run is still high, and to `PH_IDLE` otherwise. Dropping enable sends every state to `PH_IDLE`.

Top module: `i2c_scl_timer`

## Requirements
- R1: During and right after reset, `scl_drive_low` is 0, `expire` is 0 and `count` is 0.
- R2: When run and enable are high in idle, the next cycle shows `scl_drive_low` = 1 and `count` equal to `reload_cfg[RELOAD_W-1:0]`. The upper bits of `reload_cfg` have no effect.
- R3: While a phase counts, `count` drops by exactly one on each cycle in which `dec_en` is high, does not change on any other cycle, and never wraps below zero.
- R4: A low phase loaded with N ends on the (N+1)th `dec_en` after the load. The cycle after that strobe shows `scl_drive_low` = 0 and `expire` = 1. A reload of 0 therefore expires on the first strobe.
- R5: After release the counter holds at 0 until the synchronised `scl_in` reads high. Once `scl_in` rises, the reload happens on the third clock edge. With `dec_en` high every cycle and the line held low by a slave for S extra cycles, the line stays released for N+4+S cycles.
- R6: When the high phase expires, `expire` pulses. If run is high, `scl_drive_low` returns to 1 with `count` reloaded to N and no new request. If run is low, the line stays released and `count` stays 0.
- R7: The level on `scl_in` has no effect on the low phase: its length and count sequence are the same whatever the line reads.
- R8: One cycle after enable goes low, `scl_drive_low` is 0, `count` is 0 and `expire` is 0, and no expiry pulse occurs while enable stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oscillator) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Generator enable; low forces idle |
| run | input | 1 | Sequencer request to keep clocking the line |
| dec_en | input | 1 | Decrement strobe, twice per instruction cycle |
| reload_cfg | input | CFG_W | Configuration byte; low RELOAD_W bits give the reload |
| scl_in | input | 1 | Sampled level of the clock line |
| scl_drive_low | output | 1 | 1 pulls the open-drain clock line low |
| expire | output | 1 | One-cycle pulse when a phase times out |
| count | output | RELOAD_W | Current counter value |

## Verification
The bench builds the timer with RELOAD_W = 4 and CFG_W = 6. This puts all sixteen reload values, including zero, within one sweep, and leaves two upper configuration bits to vary as junk. For every reload, the sweep applies slave stretch of 0, 1 and 3 cycles and two strobe patterns (every cycle and every other cycle). The expected low-phase strobe count, the count sequence and the released-line length N+4+S all follow arithmetically. Disable during auto-reload, a forced-high line during the low phase, and a final run-low stop are also covered.

// File: rtl/brg_pkg.sv
package brg_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } phase_e;

endpackage

// File: rtl/scl_level_sync.sv
module scl_level_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_sync
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= line_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign line_sync = chain_q[STAGES-1];

endmodule

// File: rtl/brg_down_counter.sv
module brg_down_counter #(
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             dec,
    output logic [WIDTH-1:0] cnt,
    output logic             zero
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (clr)              cnt_q <= '0;
        else if (load)             cnt_q <= load_val;
        else if (dec && cnt_q != '0) cnt_q <= cnt_q - ONE;
    end

    assign cnt  = cnt_q;
    assign zero = (cnt_q == '0);

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr) |=> (cnt == $past(load_val)));                      // R2
    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && !clr && !zero) |=> (cnt == $past(cnt) - ONE));     // R3
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);                                          // R3
    AST_HOLD_NO_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec && !load && !clr) |=> $stable(cnt));                          // R3

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer #(
    parameter int CFG_W       = 8,
    parameter int RELOAD_W    = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                run,
    input  logic                dec_en,
    input  logic [CFG_W-1:0]    reload_cfg,
    input  logic                scl_in,
    output logic                scl_drive_low,
    output logic                expire,
    output logic [RELOAD_W-1:0] count
);
    import brg_pkg::*;

    localparam int SPARE_W = CFG_W - RELOAD_W;

    phase_e state_q, state_d;
    logic   scl_sync;
    logic   cnt_zero;
    logic   ld, clr, ev;
    logic   drive_q, expire_q;
    logic [RELOAD_W-1:0] reload_val;
    logic [SPARE_W-1:0]  cfg_unused;

    assign reload_val = reload_cfg[RELOAD_W-1:0];
    assign cfg_unused = reload_cfg[CFG_W-1:RELOAD_W];

    scl_level_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (scl_in),
        .line_sync (scl_sync)
    );

    brg_down_counter #(.WIDTH(RELOAD_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .load     (ld),
        .load_val (reload_val),
        .dec      (dec_en),
        .cnt      (count),
        .zero     (cnt_zero)
    );

    // Next-state and counter control
    always_comb begin
        state_d = state_q;
        ld      = 1'b0;
        clr     = 1'b0;
        ev      = enable && dec_en && cnt_zero &&
                  (state_q == PH_LOW || state_q == PH_HIGH);
        if (!enable) begin
            state_d = PH_IDLE;
            clr     = 1'b1;
        end else begin
            unique case (state_q)
                PH_IDLE: begin
                    if (run) begin
                        state_d = PH_LOW;
                        ld      = 1'b1;
                    end
                end
                PH_LOW: begin
                    if (ev) state_d = PH_WAIT;
                end
                PH_WAIT: begin
                    if (scl_sync) begin
                        state_d = PH_HIGH;
                        ld      = 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (ev) begin
                        if (run) begin
                            state_d = PH_LOW;
                            ld      = 1'b1;
                        end else begin
                            state_d = PH_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_q  <= 1'b0;
            expire_q <= 1'b0;
        end else begin
            drive_q  <= (state_d == PH_LOW);
            expire_q <= ev;
        end
    end

    assign scl_drive_low = drive_q;
    assign expire        = expire_q;

    AST_RELEASE_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_drive_low && !expire && count == '0));            // R8
    AST_WAIT_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_WAIT) |-> cnt_zero);                                 // R5
    AST_RELOAD_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_HIGH && $past(state_q) == PH_WAIT) |-> $past(scl_sync)); // R5
    AST_EXPIRE_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> $past(cnt_zero && dec_en && enable));                    // R4
    AST_LOW_IGNORES_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_LOW && enable && !(dec_en && cnt_zero)) |=> scl_drive_low); // R7

endmodule

// File: tb/i2c_scl_timer_tb.sv
module i2c_scl_timer_tb;
    localparam int RW = 4;
    localparam int CW = 6;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n, enable, run, dec_en;
    logic [CW-1:0] reload_cfg;
    logic          stretch, force_hi;
    logic          scl_in;
    logic          scl_drive_low, expire;
    logic [RW-1:0] count;

    int vectors = 0;
    int miscompares = 0;

    assign scl_in = force_hi | (~scl_drive_low & ~stretch);

    i2c_scl_timer #(.CFG_W(CW), .RELOAD_W(RW), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .run(run), .dec_en(dec_en),
        .reload_cfg(reload_cfg), .scl_in(scl_in),
        .scl_drive_low(scl_drive_low), .expire(expire), .count(count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_cycle(input int n, input int s, input int pat);
        int  pulses;
        bit  dec_last;
        int  j;
        reload_cfg = CW'((((n * 3 + s + pat) & 3) << RW) | n);
        enable   = 1'b1;
        run      = 1'b1;
        stretch  = 1'b1;
        force_hi = (n >= 4) && (n % 2 == 1);
        dec_en   = 1'b0;
        @(negedge clk);
        check(scl_drive_low == 1'b1, "R2 drive low after start", int'(scl_drive_low), 1);
        check(int'(count) == n, "R2 reload low bits only", int'(count), n);
        // low phase
        pulses   = 0;
        dec_last = 1'b1;
        dec_en   = dec_last;
        j        = 0;
        while (j < 100) begin
            @(negedge clk);
            j++;
            if (j == 2) force_hi = 1'b0;
            if (dec_last) pulses++;
            if (scl_drive_low) begin
                check(int'(count) == n - pulses, "R3 R7 low count", int'(count), n - pulses);
            end else begin
                check(pulses == n + 1, "R4 strobes in low phase", pulses, n + 1);
                check(expire == 1'b1, "R4 expiry pulse", int'(expire), 1);
                break;
            end
            dec_last = (pat == 0) ? 1'b1 : ~dec_last;
            dec_en   = dec_last;
        end
        // released phase: sample 1 taken
        force_hi = 1'b0;
        dec_en   = 1'b1;
        j        = 1;
        if (s == 0) stretch = 1'b0;
        while (j < 100) begin
            @(negedge clk);
            j++;
            if (scl_drive_low) break;
            if (j == 1 + s) stretch = 1'b0;
            if (j == 3 + s)
                check(count == '0, "R5 hold zero while waiting", int'(count), 0);
            if (j == 4 + s)
                check(int'(count) == n, "R5 reload after high seen", int'(count), n);
        end
        check(j - 1 == n + 4 + s, "R5 released length", j - 1, n + 4 + s);
        check(expire == 1'b1, "R6 high expiry pulse", int'(expire), 1);
        check(int'(count) == n, "R6 auto reload", int'(count), n);
        // disable while low
        enable = 1'b0;
        @(negedge clk);
        check(!scl_drive_low && count == '0 && !expire, "R8 disable clears",
              int'(scl_drive_low) + int'(count) + int'(expire), 0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(!expire && !scl_drive_low, "R8 quiet while disabled",
                  int'(expire) + int'(scl_drive_low), 0);
        end
        run = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int expires;
        int drove;
        rst_n = 1'b0; enable = 1'b0; run = 1'b0; dec_en = 1'b0;
        reload_cfg = '0; stretch = 1'b1; force_hi = 1'b0;
        repeat (3) @(negedge clk);
        check(!scl_drive_low && !expire && count == '0, "R1 in reset",
              int'(scl_drive_low) + int'(expire) + int'(count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!scl_drive_low && !expire && count == '0, "R1 after reset",
              int'(scl_drive_low) + int'(expire) + int'(count), 0);

        for (int p = 0; p < 2; p++)
            for (int si = 0; si < 3; si++)
                for (int n = 0; n < 16; n++)
                    run_cycle(n, (si == 2) ? 3 : si, p);

        // run dropped during high phase: line stays released
        reload_cfg = CW'(3); enable = 1'b1; run = 1'b1; dec_en = 1'b1;
        stretch = 1'b0; force_hi = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 40; k++) begin
            if (!scl_drive_low) break;
            @(negedge clk);
        end
        run = 1'b0;
        expires = 0;
        drove = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (expire) expires++;
            if (scl_drive_low) drove++;
        end
        check(expires == 1, "R6 single high expiry", expires, 1);
        check(drove == 0, "R6 stays released when run low", drove, 0);
        check(count == '0, "R6 idle count", int'(count), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule